// File: doc/BRIEF.md
# Repeater expansion port controller

This block sits on the expansion side of a multiport repeater. It lets several repeater devices share one 5-bit data bus that an external arbiter controls. When the repeater core has data to send, the block raises an activity request. It waits for the arbiter's active-low enable, and only after that enable has been qualified does it turn on its output drivers. The outgoing data carries a forwarded clock with it, so that a neighbouring device can use that clock to capture the data.

Both the arbiter enable and the forced-jam input pass through a minimum-width filter before they take effect. At the 100 MHz sampling clock the filter needs four consecutive active samples, which is 40 ns. It lets go on the first inactive sample. A qualified jam input asks every port to send jam patterns.

The block also builds a combined jam output. That output is the OR of the per-port carrier-integrity jam flags, plus any internal collision that did not come from the jam input. When the bus carrier-sense input is high, the block captures bus data into the receive path.

The bus pins are split into three signals: an input, an output value and an output enable. A pad cell outside this block joins them into the bidirectional bus.

Top module: `rptx_xport`

## Requirements
- R1: During reset and right after it, `bus_d_oe`, `bus_d_out`, `bus_clk_out`, `data_act`, `jam_req`, `rx_valid` and `rx_data` are all zero, so the bus is an input by default.
- R2: `data_act` is 1 after a clock edge at which `bus_en_n` has been sampled low at that edge and the 3 edges before it (4 consecutive samples). A low run of 3 or fewer samples never raises it. It returns to 0 after the first edge that samples `bus_en_n` high.
- R3: `bus_d_oe` is 1 after an edge where the enable is qualified (as in R2) and `tx_req` is sampled high. In that case `bus_d_out` equals the `tx_data` sampled at that edge. In every other case `bus_d_oe` is 0 and `bus_d_out` is 0.
- R4: `bus_clk_out` equals the inverted local clock while `bus_d_oe` is 1. That is, it is high during the low phase of `clk`. It is held at 0 while `bus_d_oe` is 0.
- R5: `any_act` equals `tx_req` at all times.
- R6: `jam_req` (one bit per port, NPORT bits) is all ones after an edge where `jam_in` has been sampled high for 4 consecutive edges. A high run of 3 or fewer samples never raises it. It is all zeros after the first edge that samples `jam_in` low.
- R7: `jam_out` = (OR of all `port_integrity_jam` bits) OR (`int_collision` AND NOT qualified jam). The qualified jam is the value `jam_req` shows.
- R8: After an edge that samples `bus_crs` high, `rx_valid` is 1 and `rx_data` equals the `bus_d_in` sampled at that edge. After an edge that samples `bus_crs` low, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Core has data for the bus |
| tx_data | input | 5 | Data to place on the bus |
| bus_en_n | input | 1 | Arbiter drive enable, active low |
| jam_in | input | 1 | Forced-jam request from the arbiter, active high |
| bus_crs | input | 1 | Bus carrier sense |
| bus_d_in | input | 5 | Bus value seen at the pad |
| port_integrity_jam | input | NPORT | Per-port jam flags from the integrity monitors |
| int_collision | input | 1 | Collision detected inside the repeater |
| bus_d_out | output | 5 | Bus value to drive |
| bus_d_oe | output | 1 | Bus output enable |
| bus_clk_out | output | 1 | Clock forwarded with the bus data |
| any_act | output | 1 | Request to release data onto the bus |
| data_act | output | 1 | Qualified arbiter enable seen |
| jam_out | output | 1 | Combined jam indication |
| jam_req | output | NPORT | Per-port jam-pattern request |
| rx_valid | output | 1 | Captured bus data valid |
| rx_data | output | 5 | Captured bus data |

## Verification
The bench concentrates on the edges of the filters: low runs on the enable of exactly three and four samples, high runs on the jam input of the same lengths, and a gap of one sample inside a long run. A filter with an off-by-one count would drive the bus or broadcast jam on a 30 ns glitch, or would react one cycle late. A filter that failed to restart its count after a gap would accept a broken pulse as a valid one. The bench also raises internal collisions while the jam input is qualified, and a merge that omitted that exclusion would report a jam the arbiter itself caused. Finally, it samples the forwarded clock in both clock phases, which catches a clock that runs while the bus is idle or is out of phase with the data.

// File: rtl/rptx_pkg.sv
package rptx_pkg;

  localparam int DATA_W = 5;

  typedef logic [DATA_W-1:0] xdat_t;

  // combined jam: port flags always count, collisions only when not self-caused
  function automatic logic f_jam_merge(input logic any_port_jam,
                                       input logic collision,
                                       input logic jam_qualified);
    return any_port_jam | (collision & ~jam_qualified);
  endfunction

  // value to put on the bus pins for a given enable
  function automatic xdat_t f_bus_value(input logic oe, input xdat_t d);
    return oe ? d : '0;
  endfunction

endpackage

// File: rtl/rptx_qual.sv
module rptx_qual #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_active,
  output logic q,
  output logic q_nx
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;

  // saturating run length of consecutive active samples
  function automatic logic [CW-1:0] f_run(input logic [CW-1:0] r, input logic a);
    if (!a)         return '0;
    if (r == FULL)  return r;
    return r + 1'b1;
  endfunction

  assign run_nx = f_run(run_q, raw_active);
  assign q_nx   = (run_nx == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      q     <= 1'b0;
    end else begin
      run_q <= run_nx;
      q     <= q_nx;
    end
  end
endmodule

// File: rtl/rptx_drive.sv
module rptx_drive
  import rptx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  grant_nx,
  input  xdat_t tx_data,
  output logic  oe,
  output xdat_t d_out,
  output logic  clk_fwd
);
  xdat_t data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe     <= 1'b0;
      data_q <= '0;
    end else begin
      oe     <= grant_nx;
      data_q <= tx_data;
    end
  end

  assign d_out   = f_bus_value(oe, data_q);
  // oe changes just after the rising edge, while ~clk is low: no glitch
  assign clk_fwd = oe & ~clk;
endmodule

// File: rtl/rptx_jam.sv
module rptx_jam
  import rptx_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic             jam_qual,
  input  logic [NPORT-1:0] port_jam,
  input  logic             collision,
  output logic             jam_out,
  output logic [NPORT-1:0] jam_req
);
  logic any_port;

  assign any_port = |port_jam;
  assign jam_out  = f_jam_merge(any_port, collision, jam_qual);

  for (genvar p = 0; p < NPORT; p++) begin : g_fan
    assign jam_req[p] = jam_qual;
  end
endmodule

// File: rtl/rptx_rx.sv
module rptx_rx
  import rptx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  crs,
  input  xdat_t d_in,
  output logic  valid,
  output xdat_t data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= crs;
      data  <= f_bus_value(crs, d_in);
    end
  end
endmodule

// File: rtl/rptx_xport.sv
module rptx_xport
  import rptx_pkg::*;
#(
  parameter int NPORT        = 8,
  parameter int FILT_SAMPLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_req,
  input  logic [DATA_W-1:0]        tx_data,
  input  logic                     bus_en_n,
  input  logic                     jam_in,
  input  logic                     bus_crs,
  input  logic [DATA_W-1:0]        bus_d_in,
  input  logic [NPORT-1:0]         port_integrity_jam,
  input  logic                     int_collision,
  output logic [DATA_W-1:0]        bus_d_out,
  output logic                     bus_d_oe,
  output logic                     bus_clk_out,
  output logic                     any_act,
  output logic                     data_act,
  output logic                     jam_out,
  output logic [NPORT-1:0]         jam_req,
  output logic                     rx_valid,
  output logic [DATA_W-1:0]        rx_data
);
  // named internal events
  logic en_qual, en_qual_nx;
  logic jam_qual, jam_qual_nx;
  logic drive_grant_nx;

  rptx_qual #(.N(FILT_SAMPLES)) u_en_filt (
    .clk(clk), .rst_n(rst_n), .raw_active(~bus_en_n),
    .q(en_qual), .q_nx(en_qual_nx)
  );

  rptx_qual #(.N(FILT_SAMPLES)) u_jam_filt (
    .clk(clk), .rst_n(rst_n), .raw_active(jam_in),
    .q(jam_qual), .q_nx(jam_qual_nx)
  );

  assign drive_grant_nx = en_qual_nx & tx_req;

  rptx_drive u_drive (
    .clk(clk), .rst_n(rst_n), .grant_nx(drive_grant_nx), .tx_data(tx_data),
    .oe(bus_d_oe), .d_out(bus_d_out), .clk_fwd(bus_clk_out)
  );

  rptx_jam #(.NPORT(NPORT)) u_jam (
    .jam_qual(jam_qual), .port_jam(port_integrity_jam),
    .collision(int_collision), .jam_out(jam_out), .jam_req(jam_req)
  );

  rptx_rx u_rx (
    .clk(clk), .rst_n(rst_n), .crs(bus_crs), .d_in(bus_d_in),
    .valid(rx_valid), .data(rx_data)
  );

  assign any_act  = tx_req;
  assign data_act = en_qual;

  logic unused_nx;
  assign unused_nx = jam_qual_nx;
endmodule

// File: rtl/rptx_xport_chk.sv
module rptx_xport_chk #(
  parameter int NPORT        = 8,
  parameter int FILT_SAMPLES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_req,
  input logic                 bus_en_n,
  input logic                 jam_in,
  input logic                 bus_crs,
  input logic [NPORT-1:0]     port_integrity_jam,
  input logic [4:0]           bus_d_out,
  input logic                 bus_d_oe,
  input logic                 any_act,
  input logic                 data_act,
  input logic                 jam_out,
  input logic [NPORT-1:0]     jam_req,
  input logic                 rx_valid
);
  // independent run-length counters for the filter windows
  int en_run, jam_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_run  <= 0;
      jam_run <= 0;
    end else begin
      en_run  <= bus_en_n ? 0 : ((en_run  < FILT_SAMPLES) ? en_run  + 1 : en_run);
      jam_run <= jam_in   ? ((jam_run < FILT_SAMPLES) ? jam_run + 1 : jam_run) : 0;
    end
  end

  // R2
  en_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_act |-> en_run >= FILT_SAMPLES);
  // R3
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_d_oe |-> data_act);
  // R3
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_d_oe |-> bus_d_out == '0);
  // R5
  any_act_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_act == tx_req);
  // R6
  jam_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|jam_req) |-> jam_run >= FILT_SAMPLES);
  // R6
  jam_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(jam_req) == 0 || $countones(jam_req) == NPORT);
  // R7
  port_jam_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_integrity_jam) |-> jam_out);
  // R8
  rx_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bus_crs));
endmodule

bind rptx_xport rptx_xport_chk #(.NPORT(NPORT), .FILT_SAMPLES(FILT_SAMPLES)) u_chk (.*);

// File: tb/rptx_xport_tb.sv
module rptx_xport_tb;
  localparam int PERIOD = 10;
  localparam int NP     = 8;
  localparam int FN     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 0, bus_en_n = 1, jam_in = 0, bus_crs = 0, int_collision = 0;
  logic [4:0] tx_data = '0, bus_d_in = '0;
  logic [NP-1:0] pij = '0;
  logic [4:0] bus_d_out, rx_data;
  logic bus_d_oe, bus_clk_out, any_act, data_act, jam_out, rx_valid;
  logic [NP-1:0] jam_req;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  int m_en_run = 0, m_jam_run = 0;
  logic m_en = 0, m_jam = 0, m_oe = 0, m_rxv = 0;
  logic [4:0] m_dout = '0, m_rxd = '0;

  always #(PERIOD/2) clk = ~clk;

  rptx_xport #(.NPORT(NP), .FILT_SAMPLES(FN)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_data(tx_data),
    .bus_en_n(bus_en_n), .jam_in(jam_in), .bus_crs(bus_crs), .bus_d_in(bus_d_in),
    .port_integrity_jam(pij), .int_collision(int_collision),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_clk_out(bus_clk_out),
    .any_act(any_act), .data_act(data_act), .jam_out(jam_out), .jam_req(jam_req),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  function automatic logic exp_jam_out(logic [NP-1:0] p, logic c, logic jq);
    if (p != '0) return 1'b1;
    if (jq)      return 1'b0;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // one clock: update model at posedge, check both phases
  task automatic step();
    @(posedge clk);
    m_en_run  = bus_en_n ? 0 : m_en_run + 1;
    m_jam_run = jam_in ? m_jam_run + 1 : 0;
    m_en   = (m_en_run >= FN);
    m_jam  = (m_jam_run >= FN);
    m_oe   = m_en && tx_req;
    m_dout = m_oe ? tx_data : 5'd0;
    m_rxv  = bus_crs;
    m_rxd  = bus_crs ? bus_d_in : 5'd0;
    #1;
    chk("R2 data_act", data_act, m_en);
    chk("R3 bus_d_oe", bus_d_oe, m_oe);
    chk("R3 bus_d_out", bus_d_out, m_dout);
    chk("R4 clk_out high phase", bus_clk_out, 1'b0);
    chk("R5 any_act", any_act, tx_req);
    chk("R6 jam_req", jam_req, m_jam ? {NP{1'b1}} : '0);
    chk("R7 jam_out", jam_out, exp_jam_out(pij, int_collision, m_jam));
    chk("R8 rx_valid", rx_valid, m_rxv);
    chk("R8 rx_data", rx_data, m_rxd);
    @(negedge clk);
    #1;
    chk("R4 clk_out low phase", bus_clk_out, m_oe);
  endtask

  task automatic en_pulse(input int len);
    for (int i = 0; i < len; i++) begin bus_en_n = 0; step(); end
    bus_en_n = 1; step();
  endtask

  task automatic jam_pulse(input int len);
    for (int i = 0; i < len; i++) begin jam_in = 1; step(); end
    jam_in = 0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state while held
    chk("R1 oe in reset", bus_d_oe, 0);
    chk("R1 dout in reset", bus_d_out, 0);
    chk("R1 data_act in reset", data_act, 0);
    chk("R1 jam_req in reset", jam_req, 0);
    chk("R1 rx in reset", {rx_valid, rx_data}, 0);
    @(negedge clk); #1;
    chk("R1 clk_out in reset", bus_clk_out, 0);
    rst_n = 1;
    tx_req = 1; tx_data = 5'h15;
    step();
    chk("R1 oe after reset", bus_d_oe, 0);

    // R2 glitch of 3 ignored, 4 accepted, gap restarts count
    en_pulse(3);
    en_pulse(4);
    en_pulse(2); en_pulse(3);
    for (int i = 0; i < 8; i++) begin bus_en_n = 0; tx_data = 5'(i * 3); step(); end
    tx_req = 0; step(); tx_req = 1; step();
    bus_en_n = 1; step();

    // R6/R7 jam filter and collision exclusion
    int_collision = 1;
    jam_pulse(3);
    jam_pulse(4);
    for (int i = 0; i < 6; i++) begin jam_in = 1; step(); end
    int_collision = 0; step();
    pij = 8'h10; step();
    jam_in = 0; pij = '0; int_collision = 1; step();
    int_collision = 0;

    // R8 carrier sense capture
    bus_crs = 1; bus_d_in = 5'h1f; step();
    bus_d_in = 5'h0a; step();
    bus_crs = 0; step();

    // random phase with run-biased control inputs
    for (int c = 0; c < 3000; c++) begin
      if (($urandom % 5) == 0) bus_en_n = ~bus_en_n;
      if (($urandom % 6) == 0) jam_in   = ~jam_in;
      tx_req        = ($urandom % 4) != 0;
      tx_data       = 5'($urandom);
      bus_crs       = $urandom % 2;
      bus_d_in      = 5'($urandom);
      int_collision = ($urandom % 3) == 0;
      pij           = (($urandom % 5) == 0) ? NP'(1 << ($urandom % NP)) : '0;
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule